// File: doc/BRIEF.md
# Audio Clock Divider and Timer Port

This block runs entirely on one master crystal clock of about 14.318 MHz. A binary prescaler counter runs freely on that clock. Decodes on its low bits produce three single-cycle enable pulses: one for the sound CPU at a quarter of the master rate, one for the tone generator at an eighth, and a slow timer tick at 1/4096, which is every 1024 sound-CPU cycles. Each timer tick advances a small wrap-around timer count.

The block also presents a byte that the sound CPU can read. The byte holds the low bits of the timer count, merged with a busy flag from an external speech chip. A variant input selects between two board packings of that byte. A fitted input says whether a speech chip is present; when it is not, the busy flag reads as zero. Reads are combinational from the current count, and the byte is zero unless the read strobe is high.

Top module: `aud_clkdiv_timer`

## Requirements
- R1: A synchronous active-high reset clears the prescaler and the timer count to zero. In the cycle after reset, all three enables are low.
- R2: `cpu_en` is high for exactly one master cycle in every 2^CPU_LOG2 cycles (4 by default). It is high when the count of edges since reset, modulo that period, equals period-1.
- R3: `tone_en` is high for one cycle in every 2^TONE_LOG2 cycles (8 by default), on the same phase rule. It is only ever high together with `cpu_en`.
- R4: `tick_en` is high for one cycle in every 2^TICK_LOG2 cycles (4096 by default, which is 1024 `cpu_en` pulses), on the same phase rule. It is only ever high together with `tone_en`.
- R5: `tick_count` increases by one at each clock edge where `tick_en` is high. It holds otherwise and wraps modulo 2^TIMER_W.
- R6: With `variant_b`=0, `port_sel`=0 and `rd_strobe`=1, `rd_data` = {4'b0000, tick_count[3:0]}.
- R7: With `variant_b`=0, `port_sel`=1 and `rd_strobe`=1, `rd_data` = 8'h10 when `speech_busy` and `speech_fitted` are both 1, and 8'h00 otherwise.
- R8: With `variant_b`=1, `port_sel`=0 and `rd_strobe`=1, `rd_data`[1:0] = `tick_count`[1:0] and `rd_data`[2] = `speech_busy` AND `speech_fitted`. Bits 7:3 are 0, so bit 2 is 0 when no speech chip is fitted.
- R9: With `variant_b`=1, `port_sel`=1 and `rd_strobe`=1, `rd_data` = 8'h00.
- R10: With `rd_strobe`=0, `rd_data` = 8'h00, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master crystal clock |
| rst | input | 1 | Synchronous active-high reset |
| variant_b | input | 1 | 0 = board variant A packing, 1 = variant B packing |
| speech_fitted | input | 1 | 1 when a speech chip is present |
| speech_busy | input | 1 | Busy flag from the speech chip |
| rd_strobe | input | 1 | Read strobe for the status byte |
| port_sel | input | 1 | 0 = timer port, 1 = speech status port |
| cpu_en | output | 1 | Sound CPU clock enable pulse |
| tone_en | output | 1 | Tone generator clock enable pulse |
| tick_en | output | 1 | Slow timer tick pulse |
| tick_count | output | TIMER_W | Free-running timer count |
| rd_data | output | 8 | Status byte read by the CPU |

## Verification
The bench builds the block with CPU_LOG2=2, TONE_LOG2=3, TICK_LOG2=5 and TIMER_W=4. With these values the timer ticks every 32 master cycles, so the full 16-state timer wrap arrives within about 600 cycles. At the default of 4096 cycles per tick, a wrap would take 65536 cycles. The divide-by-4 and divide-by-8 taps keep their real ratios, so the nesting of the three enables and both read packings are checked at exact phases against an edge counter kept in the bench.

// File: rtl/aud_clkdiv_pkg.sv
package aud_clkdiv_pkg;

    localparam int STATUS_W = 8;

    typedef enum logic {
        VAR_A = 1'b0,
        VAR_B = 1'b1
    } variant_e;

    typedef enum logic {
        PORT_TIMER  = 1'b0,
        PORT_SPEECH = 1'b1
    } port_e;

    typedef struct packed {
        logic cpu;
        logic tone;
        logic tick;
    } enables_t;

    // True when the lowest n bits of v are all ones.
    function automatic logic low_ones(logic [31:0] v, int n);
        logic r;
        r = 1'b1;
        for (int i = 0; i < 32; i++) begin
            if (i < n) r = r & v[i];
        end
        return r;
    endfunction

    function automatic logic [STATUS_W-1:0] pack_status(
        variant_e   vsel,
        port_e      psel,
        logic [3:0] cnt,
        logic       busy
    );
        logic [STATUS_W-1:0] b;
        b = '0;
        unique case ({vsel, psel})
            {VAR_A, PORT_TIMER}:  b[3:0] = cnt;
            {VAR_A, PORT_SPEECH}: b[4]   = busy;
            {VAR_B, PORT_TIMER}:  begin
                b[1:0] = cnt[1:0];
                b[2]   = busy;
            end
            default:              b = '0;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/aud_prescaler.sv
module aud_prescaler
    import aud_clkdiv_pkg::*;
#(
    parameter int CPU_LOG2  = 2,
    parameter int TONE_LOG2 = 3,
    parameter int TICK_LOG2 = 12
) (
    input  logic     clk,
    input  logic     rst,
    output enables_t en
);
    localparam int PRE_W = TICK_LOG2;
    localparam int NTAPS = 3;
    localparam int TAPS [NTAPS] = '{CPU_LOG2, TONE_LOG2, TICK_LOG2};

    logic [PRE_W-1:0] pre;
    logic [NTAPS-1:0] tap_hit;

    always_ff @(posedge clk) begin
        if (rst) pre <= '0;
        else     pre <= pre + 1'b1;
    end

    for (genvar g = 0; g < NTAPS; g++) begin : g_tap
        assign tap_hit[g] = low_ones(32'(pre), TAPS[g]);
    end

    assign en.cpu  = tap_hit[0];
    assign en.tone = tap_hit[1];
    assign en.tick = tap_hit[2];

    p_cpu_single_r2: assert property (@(posedge clk) disable iff (rst)
        en.cpu |=> !en.cpu);
    p_tone_in_cpu_r3: assert property (@(posedge clk) disable iff (rst)
        en.tone |-> en.cpu);
    p_tick_in_tone_r4: assert property (@(posedge clk) disable iff (rst)
        en.tick |-> en.tone);

endmodule

// File: rtl/aud_tick_counter.sv
module aud_tick_counter #(
    parameter int TIMER_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               tick,
    output logic [TIMER_W-1:0] count
);
    always_ff @(posedge clk) begin
        if (rst)       count <= '0;
        else if (tick) count <= count + 1'b1;
    end

    p_tick_step_r5: assert property (@(posedge clk) disable iff (rst)
        tick |=> count == $past(count) + 1'b1);
    p_tick_hold_r5: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(count));

endmodule

// File: rtl/aud_status_mux.sv
module aud_status_mux
    import aud_clkdiv_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                variant_b,
    input  logic                port_sel,
    input  logic                rd_strobe,
    input  logic                busy_raw,
    input  logic                fitted,
    input  logic [3:0]          cnt,
    output logic [STATUS_W-1:0] rd_data
);
    logic     busy_eff;
    variant_e vsel;
    port_e    psel;

    assign busy_eff = busy_raw & fitted;
    assign vsel     = variant_e'(variant_b);
    assign psel     = port_e'(port_sel);

    always_comb begin
        rd_data = '0;
        if (rd_strobe) rd_data = pack_status(vsel, psel, cnt, busy_eff);
    end

    p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_strobe |-> rd_data == '0);
    p_absent_bit2_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_strobe && variant_b && !fitted) |-> !rd_data[2]);
    p_b_speech_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (variant_b && port_sel) |-> rd_data == '0);

endmodule

// File: rtl/aud_clkdiv_timer.sv
module aud_clkdiv_timer
    import aud_clkdiv_pkg::*;
#(
    parameter int CPU_LOG2  = 2,
    parameter int TONE_LOG2 = 3,
    parameter int TICK_LOG2 = 12,
    parameter int TIMER_W   = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               variant_b,
    input  logic               speech_fitted,
    input  logic               speech_busy,
    input  logic               rd_strobe,
    input  logic               port_sel,
    output logic               cpu_en,
    output logic               tone_en,
    output logic               tick_en,
    output logic [TIMER_W-1:0] tick_count,
    output logic [7:0]         rd_data
);
    enables_t en;

    aud_prescaler #(
        .CPU_LOG2 (CPU_LOG2),
        .TONE_LOG2(TONE_LOG2),
        .TICK_LOG2(TICK_LOG2)
    ) u_pre (
        .clk(clk),
        .rst(rst),
        .en (en)
    );

    aud_tick_counter #(.TIMER_W(TIMER_W)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (en.tick),
        .count(tick_count)
    );

    aud_status_mux u_mux (
        .clk      (clk),
        .rst      (rst),
        .variant_b(variant_b),
        .port_sel (port_sel),
        .rd_strobe(rd_strobe),
        .busy_raw (speech_busy),
        .fitted   (speech_fitted),
        .cnt      (tick_count[3:0]),
        .rd_data  (rd_data)
    );

    assign cpu_en  = en.cpu;
    assign tone_en = en.tone;
    assign tick_en = en.tick;

    p_reset_quiet_r1: assert property (@(posedge clk)
        $fell(rst) |-> (tick_count == '0 && !cpu_en && !tone_en && !tick_en));

endmodule

// File: tb/aud_clkdiv_timer_tb.sv
module aud_clkdiv_timer_tb;
    localparam int CL = 2, TL = 3, KL = 5, TW = 4;
    localparam int CP = 1 << CL, TP = 1 << TL, KP = 1 << KL;

    logic clk = 0, rst = 1;
    logic variant_b = 0, speech_fitted = 0, speech_busy = 0, rd_strobe = 0, port_sel = 0;
    logic cpu_en, tone_en, tick_en;
    logic [TW-1:0] tick_count;
    logic [7:0] rd_data;
    int n = 0;
    int tests = 0, fails = 0;

    aud_clkdiv_timer #(.CPU_LOG2(CL), .TONE_LOG2(TL), .TICK_LOG2(KL), .TIMER_W(TW)) u_dut (
        .clk(clk), .rst(rst), .variant_b(variant_b), .speech_fitted(speech_fitted),
        .speech_busy(speech_busy), .rd_strobe(rd_strobe), .port_sel(port_sel),
        .cpu_en(cpu_en), .tone_en(tone_en), .tick_en(tick_en),
        .tick_count(tick_count), .rd_data(rd_data));

    always #10 clk = ~clk;

    always @(posedge clk) begin
        if (rst) n <= 0;
        else     n <= n + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int exp_count();
        return (n / KP) % (1 << TW);
    endfunction

    task automatic step();
        @(negedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst = 1;
        repeat (3) @(posedge clk);
        step();
        chk(tick_count == 0, "R1", tick_count, 0);
        chk({cpu_en, tone_en, tick_en} == 3'b000, "R1", {cpu_en, tone_en, tick_en}, 0);
        @(negedge clk);
        rst = 0;
        step();
        chk({cpu_en, tone_en, tick_en} == 3'b000, "R1", {cpu_en, tone_en, tick_en}, 0);
    endtask

    task automatic t_enables(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            step();
            chk(cpu_en  == ((n % CP) == CP - 1), "R2", cpu_en,  (n % CP) == CP - 1);
            chk(tone_en == ((n % TP) == TP - 1), "R3", tone_en, (n % TP) == TP - 1);
            chk(tick_en == ((n % KP) == KP - 1), "R4", tick_en, (n % KP) == KP - 1);
        end
    endtask

    task automatic t_timer(input int cycles);
        for (int i = 0; i < cycles; i++) begin
            step();
            chk(int'(tick_count) == exp_count(), "R5", tick_count, exp_count());
        end
    endtask

    task automatic t_read_a();
        variant_b = 0;
        rd_strobe = 1;
        port_sel = 0;
        for (int i = 0; i < 80; i++) begin
            step();
            chk(rd_data == 8'(exp_count() & 15), "R6", rd_data, exp_count() & 15);
        end
        port_sel = 1;
        for (int k = 0; k < 4; k++) begin
            speech_fitted = k[1];
            speech_busy = k[0];
            step();
            chk(rd_data == ((k == 3) ? 8'h10 : 8'h00), "R7", rd_data, (k == 3) ? 8'h10 : 8'h00);
        end
        rd_strobe = 0;
    endtask

    task automatic t_read_b();
        variant_b = 1;
        rd_strobe = 1;
        port_sel = 0;
        for (int i = 0; i < 80; i++) begin
            speech_fitted = i[3];
            speech_busy = i[2];
            step();
            chk(rd_data == 8'((exp_count() & 3) | ((i[3] & i[2]) ? 4 : 0)), "R8", rd_data,
                (exp_count() & 3) | ((i[3] & i[2]) ? 4 : 0));
        end
        speech_fitted = 0;
        speech_busy = 1;
        step();
        chk(rd_data[2] == 1'b0, "R8", rd_data, exp_count() & 3);
        port_sel = 1;
        speech_fitted = 1;
        for (int i = 0; i < 40; i++) begin
            step();
            chk(rd_data == 8'h00, "R9", rd_data, 0);
        end
        rd_strobe = 0;
    endtask

    task automatic t_idle();
        rd_strobe = 0;
        speech_fitted = 1;
        speech_busy = 1;
        for (int k = 0; k < 4; k++) begin
            variant_b = k[1];
            port_sel = k[0];
            repeat (9) @(posedge clk);
            step();
            chk(rd_data == 8'h00, "R10", rd_data, 0);
        end
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_enables(100);
                t_timer(600);
                t_read_a();
                t_read_b();
                t_idle();
                t_reset();
                t_timer(40);
            end
            begin
                repeat (20000) @(posedge clk);
                tests++;
                fails++;
                $display("FAIL watchdog actual=expired expected=done");
            end
        join_any
        disable fork;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule